// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the address and byte-count engine of a single DMA channel. It holds the working source address, destination address and remaining byte count, together with shadow copies used to restart the channel. Each read beat that the bus master completes into the channel FIFO reduces the count by the source beat size and, if enabled, moves the source address forward. Each write beat that leaves the FIFO moves the destination address forward. The source and destination beat sizes are chosen independently.

When a read beat brings the count to zero, the engine raises a count-to-zero flag. If reload is enabled, the same clock edge loads source, destination and count from their shadows, so the next transfer starts without software. If reload is off, the channel stops and raises a done flag once the FIFO reports empty. Software reaches all state through a small word-indexed register port. The interrupt output is the OR of the flags whose enables are set.

The read-beat request is a valid/ready pair. `rd_valid` is asserted while the channel runs and the remaining count covers one full source beat. A beat is taken on any clock where `rd_valid` and `rd_ready` are both high. `rd_valid` may drop without a handshake when software stops the channel or rewrites the count, and the master must not complete a beat in a cycle where `rd_valid` is low. The write-beat strobe is a plain one-cycle pulse for each beat already moved out of the FIFO.

Top module: `dma_chan_engine`

## Requirements
- R1: Width codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, and 3 is treated as 4 bytes. On a clock with `rd_valid` and `rd_ready` both high, the 24-bit count drops by the source step. `src_size`/`dst_size` output the code, with 3 shown as 2.
- R2: On each accepted read beat, the source address grows by the source step when CTRL bit 1 (source increment) is set. Otherwise it holds.
- R3: On each `wr_beat` pulse, the destination address grows by the destination step when CTRL bit 2 (destination increment) is set. Otherwise it holds. This does not depend on the channel running.
- R4: `rd_valid` is high only while the channel runs and the count is at least the source step. A beat that would take the count below zero is never requested.
- R5: An accepted beat that leaves the count at zero sets STATUS bit 1 (count-to-zero) on that edge.
- R6: If CNT_RLD bit 31 is set at count-to-zero, the same edge loads the source from SRC_RLD, the destination from DST_RLD and the count from CNT_RLD bits 23:0, and the channel keeps running. The 31-bit address shadows are zero-extended.
- R7: If reload is off at count-to-zero, the channel stops (CTRL/STATUS bit 0 reads 0). STATUS bit 2 (done) is set on the first later edge at which `fifo_empty` is high.
- R8: Writing 1 to STATUS bit 1 or bit 2 clears that flag. A set on the same edge as a clear wins.
- R9: `irq` equals (count-to-zero flag AND CTRL bit 31) OR (done flag AND CTRL bit 30).
- R10: Register words are 0 CTRL, 1 STATUS, 2 SRC, 3 DST, 4 CNT, 5 SRC_RLD, 6 DST_RLD, 7 CNT_RLD. CTRL holds run/enable in bit 0, source width in bits 5:4 and destination width in bits 7:6. A software write to a register wins over stepping, reload and stopping on the same edge.
- R11: After reset, every register reads 0 and `rd_valid`, `running` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register word written |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Register word read |
| reg_rdata | output | 32 | Read data, combinational from `reg_raddr` |
| rd_valid | output | 1 | Channel requests a read beat |
| rd_ready | input | 1 | Master completes the requested read beat |
| wr_beat | input | 1 | One write beat left the FIFO |
| fifo_empty | input | 1 | Channel FIFO is empty |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| src_size | output | 2 | Source beat size code |
| dst_size | output | 2 | Destination beat size code |
| running | output | 1 | Channel is enabled and running |
| irq | output | 1 | Channel interrupt |

## Verification
The bench builds the engine with its default parameters: 32-bit addresses, 31-bit address shadows and a 24-bit count. With these values the zero-extension of the shadows and the 24-bit count truncation are both exercised. Count writes are kept small, so count-to-zero, reload chaining, the stall on a partial last beat and the done-after-drain sequence all happen many times. Random writes hit every register, including writes on the same edge as stepping or reload.

// File: rtl/dce_pkg.sv
package dce_pkg;
  typedef enum logic [2:0] {
    REG_CTRL    = 3'd0,
    REG_STAT    = 3'd1,
    REG_SRC     = 3'd2,
    REG_DST     = 3'd3,
    REG_CNT     = 3'd4,
    REG_SRC_RLD = 3'd5,
    REG_DST_RLD = 3'd6,
    REG_CNT_RLD = 3'd7
  } reg_sel_e;

  // bytes moved per beat for a width code; code 3 behaves as word
  function automatic logic [2:0] step_bytes(input logic [1:0] code);
    case (code)
      2'd0:    step_bytes = 3'd1;
      2'd1:    step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] norm_code(input logic [1:0] code);
    norm_code = (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/dce_addr_step.sv
module dce_addr_step #(
  parameter int AW = 32,
  parameter int RW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          reload,
  input  logic [RW-1:0] rld_val,
  input  logic          step_en,
  input  logic [2:0]    step,
  output logic [AW-1:0] addr
);
  localparam int PADW = (AW > RW) ? (AW - RW) : 1;
  logic [AW-1:0] rld_ext;

  generate
    if (AW > RW) begin : g_pad
      assign rld_ext = {{PADW{1'b0}}, rld_val};
    end else begin : g_cut
      assign rld_ext = rld_val[AW-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (load)    addr <= load_val;
    else if (reload)  addr <= rld_ext;
    else if (step_en) addr <= addr + AW'(step);
  end

  // R2 R3: with no write, reload or step the address must not move
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !reload && !step_en) |=> $stable(addr));
  a_r6_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && reload) |=> (addr == AW'($past(rld_val))));
endmodule

// File: rtl/dce_count.sv
module dce_count #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  input  logic          rd_ready,
  input  logic [2:0]    step,
  input  logic          rld_en,
  input  logic [CW-1:0] rld_val,
  output logic [CW-1:0] cnt,
  output logic          rd_valid,
  output logic          fire,
  output logic          ctz_evt,
  output logic          reload_evt
);
  logic [CW-1:0] step_w, cnt_nxt;

  assign step_w     = CW'(step);
  assign rd_valid   = run && (cnt >= step_w);
  assign fire       = rd_valid && rd_ready;
  assign cnt_nxt    = cnt - step_w;
  assign ctz_evt    = fire && (cnt_nxt == '0);
  assign reload_evt = ctz_evt && rld_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (reload_evt) cnt <= rld_val;
    else if (fire)       cnt <= cnt_nxt;
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !load && !reload_evt) |=> (cnt == $past(cnt) - $past(step_w)));
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !reload_evt) |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/dce_flags.sv
module dce_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       ctrl_en,
  input  logic       stat_wr,
  input  logic [1:0] stat_clr,
  input  logic       ctz_evt,
  input  logic       rld_en,
  input  logic       fifo_empty,
  input  logic       ctz_ie,
  input  logic       done_ie,
  output logic       run,
  output logic       ctz_flag,
  output logic       done_flag,
  output logic       irq
);
  logic pend, done_set, stop_evt;

  assign stop_evt = ctz_evt && !rld_en;
  assign done_set = pend && fifo_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run       <= 1'b0;
      pend      <= 1'b0;
      ctz_flag  <= 1'b0;
      done_flag <= 1'b0;
    end else begin
      if (ctrl_wr)       run <= ctrl_en;
      else if (stop_evt) run <= 1'b0;
      if (stop_evt)      pend <= 1'b1;
      else if (done_set) pend <= 1'b0;
      ctz_flag  <= (ctz_flag  && !(stat_wr && stat_clr[0])) || ctz_evt;
      done_flag <= (done_flag && !(stat_wr && stat_clr[1])) || done_set;
    end
  end

  assign irq = (ctz_flag && ctz_ie) || (done_flag && done_ie);

  a_r5_ctz_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ctz_evt |=> ctz_flag);
  a_r7_stop_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !ctrl_wr) |=> !run);
  a_r7_done_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && fifo_empty) |=> done_flag);
  a_r8_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_clr[1] && !done_set) |=> !done_flag);
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dce_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RLD_W  = 31,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_waddr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [2:0]        reg_raddr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              rd_valid,
  input  logic              rd_ready,
  input  logic              wr_beat,
  input  logic              fifo_empty,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [1:0]        src_size,
  output logic [1:0]        dst_size,
  output logic              running,
  output logic              irq
);
  logic             src_inc, dst_inc, done_ie, ctz_ie, rld_en;
  logic [1:0]       src_w, dst_w;
  logic [RLD_W-1:0] src_rld, dst_rld;
  logic [CNT_W-1:0] cnt_rld, cnt;
  logic [2:0]       sstep, dstep;
  logic             fire, ctz_evt, reload_evt, run, ctz_flag, done_flag;
  logic             wr_ctrl, wr_stat, wr_src, wr_dst, wr_cnt;

  assign wr_ctrl = reg_wr && (reg_waddr == REG_CTRL);
  assign wr_stat = reg_wr && (reg_waddr == REG_STAT);
  assign wr_src  = reg_wr && (reg_waddr == REG_SRC);
  assign wr_dst  = reg_wr && (reg_waddr == REG_DST);
  assign wr_cnt  = reg_wr && (reg_waddr == REG_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_inc <= 1'b0; dst_inc <= 1'b0; src_w <= 2'd0; dst_w <= 2'd0;
      done_ie <= 1'b0; ctz_ie <= 1'b0;
      src_rld <= '0; dst_rld <= '0; cnt_rld <= '0; rld_en <= 1'b0;
    end else if (reg_wr) begin
      case (reg_waddr)
        REG_CTRL: begin
          src_inc <= reg_wdata[1];
          dst_inc <= reg_wdata[2];
          src_w   <= reg_wdata[5:4];
          dst_w   <= reg_wdata[7:6];
          done_ie <= reg_wdata[30];
          ctz_ie  <= reg_wdata[31];
        end
        REG_SRC_RLD: src_rld <= reg_wdata[RLD_W-1:0];
        REG_DST_RLD: dst_rld <= reg_wdata[RLD_W-1:0];
        REG_CNT_RLD: begin
          cnt_rld <= reg_wdata[CNT_W-1:0];
          rld_en  <= reg_wdata[31];
        end
        default: ;
      endcase
    end
  end

  assign sstep = step_bytes(src_w);
  assign dstep = step_bytes(dst_w);

  dce_count #(.CW(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(wr_cnt), .load_val(reg_wdata[CNT_W-1:0]),
    .run(run), .rd_ready(rd_ready), .step(sstep), .rld_en(rld_en),
    .rld_val(cnt_rld), .cnt(cnt), .rd_valid(rd_valid), .fire(fire),
    .ctz_evt(ctz_evt), .reload_evt(reload_evt)
  );

  dce_addr_step #(.AW(ADDR_W), .RW(RLD_W)) u_src (
    .clk(clk), .rst_n(rst_n), .load(wr_src), .load_val(reg_wdata[ADDR_W-1:0]),
    .reload(reload_evt), .rld_val(src_rld), .step_en(fire && src_inc),
    .step(sstep), .addr(src_addr)
  );

  dce_addr_step #(.AW(ADDR_W), .RW(RLD_W)) u_dst (
    .clk(clk), .rst_n(rst_n), .load(wr_dst), .load_val(reg_wdata[ADDR_W-1:0]),
    .reload(reload_evt), .rld_val(dst_rld), .step_en(wr_beat && dst_inc),
    .step(dstep), .addr(dst_addr)
  );

  dce_flags u_flags (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(wr_ctrl), .ctrl_en(reg_wdata[0]),
    .stat_wr(wr_stat), .stat_clr(reg_wdata[2:1]), .ctz_evt(ctz_evt),
    .rld_en(rld_en), .fifo_empty(fifo_empty), .ctz_ie(ctz_ie),
    .done_ie(done_ie), .run(run), .ctz_flag(ctz_flag),
    .done_flag(done_flag), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_raddr)
      REG_CTRL: begin
        reg_rdata[0]   = run;
        reg_rdata[1]   = src_inc;
        reg_rdata[2]   = dst_inc;
        reg_rdata[5:4] = src_w;
        reg_rdata[7:6] = dst_w;
        reg_rdata[30]  = done_ie;
        reg_rdata[31]  = ctz_ie;
      end
      REG_STAT:    reg_rdata[2:0] = {done_flag, ctz_flag, run};
      REG_SRC:     reg_rdata = DATA_W'(src_addr);
      REG_DST:     reg_rdata = DATA_W'(dst_addr);
      REG_CNT:     reg_rdata = DATA_W'(cnt);
      REG_SRC_RLD: reg_rdata = DATA_W'(src_rld);
      REG_DST_RLD: reg_rdata = DATA_W'(dst_rld);
      default: begin
        reg_rdata[CNT_W-1:0] = cnt_rld;
        reg_rdata[31]        = rld_en;
      end
    endcase
  end

  assign src_size = norm_code(src_w);
  assign dst_size = norm_code(dst_w);
  assign running  = run;

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ctz_flag || done_flag));
  a_r4_valid_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> running);
endmodule

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_waddr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic rd_valid, rd_ready = 1'b0, wr_beat = 1'b0, fifo_empty = 1'b0;
  logic [31:0] src_addr, dst_addr;
  logic [1:0] src_size, dst_size;
  logic running, irq;

  int vectors = 0, miscompares = 0;

  always #10 clk = ~clk;

  dma_chan_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .wr_beat(wr_beat),
    .fifo_empty(fifo_empty), .src_addr(src_addr), .dst_addr(dst_addr),
    .src_size(src_size), .dst_size(dst_size), .running(running), .irq(irq)
  );

  // behavioural reference state
  logic [31:0] m_src, m_dst;
  logic [30:0] m_srld, m_drld;
  logic [23:0] m_cnt, m_crld;
  logic m_rlden, m_run, m_ctz, m_done, m_pend;
  logic m_sinc, m_dinc, m_die, m_cie;
  logic [1:0] m_sw, m_dw;

  function automatic int stp(input logic [1:0] c);
    return (c == 2'd0) ? 1 : (c == 2'd1) ? 2 : 4;
  endfunction
  function automatic logic [1:0] nc(input logic [1:0] c);
    return (c == 2'd3) ? 2'd2 : c;
  endfunction
  function automatic logic m_rdv();
    return m_run && (int'(m_cnt) >= stp(m_sw));
  endfunction
  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return {m_cie, m_die, 22'd0, m_dw, m_sw, 1'b0, m_dinc, m_sinc, m_run};
      3'd1: return {29'd0, m_done, m_ctz, m_run};
      3'd2: return m_src;
      3'd3: return m_dst;
      3'd4: return {8'd0, m_cnt};
      3'd5: return {1'b0, m_srld};
      3'd6: return {1'b0, m_drld};
      default: return {m_rlden, 7'd0, m_crld};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    string rt;
    case (reg_raddr)
      3'd0: rt = "R10 ctrl";
      3'd1: rt = "R5 R7 R8 status";
      3'd2: rt = "R2 src read";
      3'd3: rt = "R3 dst read";
      3'd4: rt = "R1 count read";
      default: rt = "R6 shadow read";
    endcase
    chk(rt, reg_rdata, m_read(reg_raddr));
    chk("R2 src_addr", src_addr, m_src);
    chk("R3 dst_addr", dst_addr, m_dst);
    chk("R4 rd_valid", {31'd0, rd_valid}, {31'd0, m_rdv()});
    chk("R7 running", {31'd0, running}, {31'd0, m_run});
    chk("R9 irq", {31'd0, irq}, {31'd0, (m_ctz && m_cie) || (m_done && m_die)});
    chk("R1 sizes", {28'd0, src_size, dst_size}, {28'd0, nc(m_sw), nc(m_dw)});
  endtask

  // compare, then drive one cycle of stimulus and advance the model
  task automatic cyc(input logic wr, input logic [2:0] wa, input logic [31:0] wd,
                     input logic [2:0] ra, input logic rdy, input logic wb,
                     input logic fe);
    int s, d;
    logic fire, ctz, rl, dset;
    logic [23:0] nxt;
    @(negedge clk);
    compare_all();
    reg_wr = wr; reg_waddr = wa; reg_wdata = wd; reg_raddr = ra;
    rd_ready = rdy; wr_beat = wb; fifo_empty = fe;
    s = stp(m_sw); d = stp(m_dw);
    fire = m_rdv() && rdy;
    nxt  = m_cnt - 24'(s);
    ctz  = fire && (nxt == 24'd0);
    rl   = ctz && m_rlden;
    dset = m_pend && fe;
    // addresses and count: write > reload > step
    if (wr && wa == 3'd2) m_src = wd;
    else if (rl) m_src = {1'b0, m_srld};
    else if (fire && m_sinc) m_src = m_src + 32'(s);
    if (wr && wa == 3'd3) m_dst = wd;
    else if (rl) m_dst = {1'b0, m_drld};
    else if (wb && m_dinc) m_dst = m_dst + 32'(d);
    if (wr && wa == 3'd4) m_cnt = wd[23:0];
    else if (rl) m_cnt = m_crld;
    else if (fire) m_cnt = nxt;
    // flags
    m_ctz  = (m_ctz && !(wr && wa == 3'd1 && wd[1])) || ctz;
    m_done = (m_done && !(wr && wa == 3'd1 && wd[2])) || dset;
    if (ctz && !m_rlden) m_pend = 1'b1;
    else if (dset) m_pend = 1'b0;
    if (wr && wa == 3'd0) m_run = wd[0];
    else if (ctz && !m_rlden) m_run = 1'b0;
    // configuration and shadows
    if (wr && wa == 3'd0) begin
      m_sinc = wd[1]; m_dinc = wd[2]; m_sw = wd[5:4]; m_dw = wd[7:6];
      m_die = wd[30]; m_cie = wd[31];
    end
    if (wr && wa == 3'd5) m_srld = wd[30:0];
    if (wr && wa == 3'd6) m_drld = wd[30:0];
    if (wr && wa == 3'd7) begin m_crld = wd[23:0]; m_rlden = wd[31]; end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    miscompares++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    m_src = '0; m_dst = '0; m_srld = '0; m_drld = '0; m_cnt = '0; m_crld = '0;
    m_rlden = 0; m_run = 0; m_ctz = 0; m_done = 0; m_pend = 0;
    m_sinc = 0; m_dinc = 0; m_die = 0; m_cie = 0; m_sw = 0; m_dw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state across every register word
    for (int a = 0; a < 8; a++) begin
      reg_raddr = 3'(a);
      #1 chk("R11 reset read", reg_rdata, 32'd0);
    end
    chk("R11 reset outputs", {29'd0, rd_valid, running, irq}, 32'd0);
    // directed: halfword source, byte dest, 6 bytes, no reload
    cyc(1, 3'd2, 32'h100, 3'd0, 0, 0, 0);
    cyc(1, 3'd3, 32'h200, 3'd0, 0, 0, 0);
    cyc(1, 3'd4, 32'd6,   3'd0, 0, 0, 0);
    cyc(1, 3'd0, 32'hC000_0017, 3'd0, 0, 0, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0, 3'd4, 1, 1, 0);
    cyc(0, 0, 0, 3'd1, 0, 0, 1);
    cyc(0, 0, 0, 3'd1, 0, 0, 1);
    chk("R5 ctz flag", {31'd0, reg_rdata[1]}, 32'd1);
    cyc(1, 3'd1, 32'h6, 3'd1, 0, 0, 0);
    // directed: word source with 3 bytes left stalls (R4)
    cyc(1, 3'd4, 32'd3, 3'd4, 0, 0, 0);
    cyc(1, 3'd0, 32'h0000_0023, 3'd4, 1, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 3'd4, 1, 0, 0);
    // directed: reload chaining (R6)
    cyc(1, 3'd5, 32'hFFFF_FFF0, 3'd5, 0, 0, 0);
    cyc(1, 3'd6, 32'h0000_0400, 3'd6, 0, 0, 0);
    cyc(1, 3'd7, 32'h8000_0004, 3'd7, 0, 0, 0);
    cyc(1, 3'd4, 32'd4, 3'd4, 0, 0, 0);
    cyc(1, 3'd0, 32'h4000_0027, 3'd4, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, 3'd2, 1, 1, 1);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic wr;
      logic [2:0] wa;
      logic [31:0] wd;
      wr = ($urandom % 10) == 0;
      wa = 3'($urandom % 8);
      wd = $urandom;
      if (wa == 3'd4 || wa == 3'd7) wd = {wd[31], 7'd0, 24'($urandom % 24)};
      if (wa == 3'd0 && ($urandom % 4) != 0) wd[0] = 1'b1;
      cyc(wr, wa, wd, 3'($urandom % 8), 1'($urandom % 2),
          1'($urandom % 2), ($urandom % 3) == 0);
    end
    cyc(0, 0, 0, 3'd1, 0, 0, 0);
    finish_run();
  end
endmodule